// File: doc/BRIEF.md
# Dual 24-bit down-counting timer

This peripheral holds two identical countdown channels behind a small register bus (byte address, write strobe, 32-bit write data, 32-bit read data). Each channel has a configuration register and an initial-count register. A channel that is running loads its initial count, then decrements once per prescaled tick. When it reaches zero it flags its bit in a shared status register. A one-shot channel then halts itself. A periodic channel reloads and keeps counting.

Channel 1 is meant to serve as a free-running time base, so its live count can be read. Channel 0 is meant to produce timed events through the interrupt. Status bits are cleared by writing ones. A single interrupt line is high while any status bit is set whose channel has its interrupt enable set. Reads are combinational from the address. A write takes effect on the rising clock edge on which the write strobe is high.

Top module: `twin_countdown_timer`

## Requirements
- R1: After reset, both configuration registers read 0x00000001 (prescale 1, everything else clear). The initial-count, live-count and status registers read 0, and `irq` is low.
- R2: Byte offsets are as follows. Configuration of channel 0 is at 0x00 and of channel 1 at 0x04. Initial count of channel 0 is at 0x08 and of channel 1 at 0x0C. The live count of channel 1 is at 0x14 and status is at 0x18. Any other offset reads 0. In a configuration register, bit 30 is run, bit 29 is interrupt enable, bits 28:27 are the mode and bits 7:0 are the prescale; all other bits read 0. Initial counts keep bits 23:0 only.
- R3: A channel whose reload is pending loads its initial count on the first clock edge on which it is running.
- R4: With prescale P, a running channel decrements exactly once every P+1 clocks. Its first decrement comes P+1 clocks after the load.
- R5: Clearing run freezes both the count and the prescaler phase. Setting run again continues from the held values without a reload, unless R8 applies.
- R6: Mode bit 27 clear selects one-shot operation. On the tick that takes the count from 1 to 0, or on the first tick after a load of 0, the channel sets its status bit, holds 0 and clears its own run bit.
- R7: Mode bit 27 set selects periodic operation. On that same tick the channel sets its status bit, reloads its initial count and keeps running.
- R8: Writing an initial count while the channel is stopped makes a reload pending for the next enable. A write while the channel is running does not disturb the count; the new value is first used at the next periodic reload.
- R9: Status bit 0 belongs to channel 0 and bit 1 to channel 1. Writing a 1 to a bit at 0x18 clears it, and writing a 0 leaves it unchanged. If a channel sets its bit on the same edge that a write clears it, the bit ends up set.
- R10: `irq` is high exactly when some status bit is set and the same channel's interrupt enable (bit 29) is set.
- R11: Offset 0x14 reads channel 1's current count in bits 23:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W (5) | Byte offset of the access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq | output | 1 | Combined interrupt request |

## Verification
The case that is hardest to reach from the ports is a status clear that lands on the same edge on which a channel expires. The clear must lose to the new event. The bench reaches it by arming channel 0 in one-shot mode with prescale 0 and an initial count of 2, so that the expiry edge can be counted exactly. It then issues the write-one-to-clear so that the write lands on that edge. The stop and resume paths are reached by dropping run in the middle of a prescale period and reading the live count before and after the restart.

// File: rtl/tick_tmr_pkg.sv
package tick_tmr_pkg;
    localparam int DATA_W    = 32;
    localparam int NUM_CH    = 2;
    localparam int RUN_BIT   = 30;
    localparam int IE_BIT    = 29;
    localparam int MODE_LO   = 27;
    localparam int MODE_W    = 2;
    localparam int CFG_BASE  = 'h00;
    localparam int INIT_BASE = 'h08;
    localparam int CH_STRIDE = 4;
    localparam int LIVE_OFF  = 'h14;
    localparam int STAT_OFF  = 'h18;
    localparam int LIVE_CH   = 1;

    typedef enum logic {
        RUN_ONCE   = 1'b0,
        RUN_REPEAT = 1'b1
    } repeat_e;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             restart_i,
    input  logic [PRE_W-1:0] presc_i,
    output logic             tick_o
);
    typedef struct packed {
        logic [PRE_W-1:0] phase;
    } pre_state_t;

    pre_state_t pre_q, pre_d;

    assign tick_o = run_i && !restart_i && (pre_q.phase >= presc_i);

    always_comb begin
        pre_d = pre_q;
        if (run_i) begin
            if (restart_i || tick_o) begin
                pre_d.phase = '0;
            end else begin
                pre_d.phase = pre_q.phase + PRE_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_d;
        end
    end

    // R4: after a tick the phase restarts, so a tick on the next clock needs prescale 0
    a_r4_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !(tick_o && presc_i != '0));
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tick_tmr_pkg::*;
#(
    parameter int CNT_W = 24,
    parameter int PRE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we_i,
    input  logic              init_we_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] cfg_rd_o,
    output logic [CNT_W-1:0]  init_rd_o,
    output logic [CNT_W-1:0]  count_o,
    output logic              ie_o,
    output logic              expire_o
);
    typedef struct packed {
        logic              run;
        logic              ie;
        logic [MODE_W-1:0] mode;
        logic [PRE_W-1:0]  presc;
        logic [CNT_W-1:0]  init;
        logic [CNT_W-1:0]  cnt;
        logic              pend;
    } ch_state_t;

    ch_state_t ch_q, ch_d;
    logic      tick;
    logic      load;
    repeat_e   rep;
    logic      unused_wdata;

    assign unused_wdata = ^wdata_i;
    assign load     = ch_q.run && ch_q.pend;
    assign rep      = repeat_e'(ch_q.mode[0]);
    assign expire_o = tick && (ch_q.cnt <= CNT_W'(1));

    tmr_prescaler #(.PRE_W(PRE_W)) u_presc (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (ch_q.run),
        .restart_i (load),
        .presc_i   (ch_q.presc),
        .tick_o    (tick)
    );

    always_comb begin
        ch_d = ch_q;
        if (load) begin
            ch_d.cnt  = ch_q.init;
            ch_d.pend = 1'b0;
        end else if (tick) begin
            if (ch_q.cnt <= CNT_W'(1)) begin
                if (rep == RUN_REPEAT) begin
                    ch_d.cnt = ch_q.init;
                end else begin
                    ch_d.cnt  = '0;
                    ch_d.run  = 1'b0;
                    ch_d.pend = 1'b1;
                end
            end else begin
                ch_d.cnt = ch_q.cnt - CNT_W'(1);
            end
        end
        if (init_we_i) begin
            ch_d.init = wdata_i[CNT_W-1:0];
            if (!ch_q.run) begin
                ch_d.pend = 1'b1;
            end
        end
        if (cfg_we_i) begin
            ch_d.run   = wdata_i[RUN_BIT];
            ch_d.ie    = wdata_i[IE_BIT];
            ch_d.mode  = wdata_i[MODE_LO +: MODE_W];
            ch_d.presc = wdata_i[PRE_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ch_q <= '{run: 1'b0, ie: 1'b0, mode: '0, presc: PRE_W'(1),
                      init: '0, cnt: '0, pend: 1'b1};
        end else begin
            ch_q <= ch_d;
        end
    end

    always_comb begin
        cfg_rd_o                         = '0;
        cfg_rd_o[RUN_BIT]                = ch_q.run;
        cfg_rd_o[IE_BIT]                 = ch_q.ie;
        cfg_rd_o[MODE_LO +: MODE_W]      = ch_q.mode;
        cfg_rd_o[PRE_W-1:0]              = ch_q.presc;
    end

    assign init_rd_o = ch_q.init;
    assign count_o   = ch_q.cnt;
    assign ie_o      = ch_q.ie;

    // R3: a pending load copies the initial count
    a_r3_load_init: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (ch_q.cnt == $past(ch_q.init)));
    // R4: an ordinary tick takes exactly one off the count
    a_r4_dec_by_one: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && ch_q.cnt > CNT_W'(1)) |=> (ch_q.cnt == $past(ch_q.cnt) - CNT_W'(1)));
    // R5: a stopped channel keeps its count
    a_r5_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !ch_q.run |=> $stable(ch_q.cnt));
    // R6: one-shot expiry stops the channel unless software rewrites its configuration
    a_r6_oneshot_halts: assert property (@(posedge clk) disable iff (!rst_n)
        (expire_o && rep == RUN_ONCE && !cfg_we_i) |=> !ch_q.run);
    // R7: periodic expiry reloads the initial count
    a_r7_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (expire_o && rep == RUN_REPEAT) |=> (ch_q.cnt == $past(ch_q.init)));
endmodule

// File: rtl/tmr_status.sv
module tmr_status #(
    parameter int NUM_CH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] set_i,
    input  logic              clr_we_i,
    input  logic [NUM_CH-1:0] clr_mask_i,
    input  logic [NUM_CH-1:0] ie_i,
    output logic [NUM_CH-1:0] stat_o,
    output logic              irq_o
);
    typedef struct packed {
        logic [NUM_CH-1:0] flags;
    } stat_state_t;

    stat_state_t st_q, st_d;
    logic [NUM_CH-1:0] clr_eff;

    assign clr_eff = clr_we_i ? clr_mask_i : '0;

    always_comb begin
        st_d       = st_q;
        st_d.flags = (st_q.flags & ~clr_eff) | set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stat_o = st_q.flags;
    assign irq_o  = |(st_q.flags & ie_i);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        // R9: a new event wins over a clear on the same edge
        a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[i] |=> stat_o[i]);
        // R9: a written one clears the bit when no event arrives
        a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_eff[i] && !set_i[i]) |=> !stat_o[i]);
    end
endmodule

// File: rtl/twin_countdown_timer.sv
module twin_countdown_timer
    import tick_tmr_pkg::*;
#(
    parameter int CNT_W  = 24,
    parameter int PRE_W  = 8,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq
);
    logic [DATA_W-1:0] cfg_rd  [NUM_CH];
    logic [CNT_W-1:0]  init_rd [NUM_CH];
    logic [CNT_W-1:0]  count   [NUM_CH];
    logic [NUM_CH-1:0] ie;
    logic [NUM_CH-1:0] expire;
    logic [NUM_CH-1:0] stat;
    logic              stat_we;
    logic              unused_counts;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic cfg_we;
        logic init_we;
        assign cfg_we  = bus_wr && (bus_addr == ADDR_W'(CFG_BASE + i * CH_STRIDE));
        assign init_we = bus_wr && (bus_addr == ADDR_W'(INIT_BASE + i * CH_STRIDE));

        tmr_channel #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .cfg_we_i  (cfg_we),
            .init_we_i (init_we),
            .wdata_i   (bus_wdata),
            .cfg_rd_o  (cfg_rd[i]),
            .init_rd_o (init_rd[i]),
            .count_o   (count[i]),
            .ie_o      (ie[i]),
            .expire_o  (expire[i])
        );
    end

    assign stat_we = bus_wr && (bus_addr == ADDR_W'(STAT_OFF));

    tmr_status #(.NUM_CH(NUM_CH)) u_stat (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_i      (expire),
        .clr_we_i   (stat_we),
        .clr_mask_i (bus_wdata[NUM_CH-1:0]),
        .ie_i       (ie),
        .stat_o     (stat),
        .irq_o      (irq)
    );

    assign unused_counts = ^count[0];

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (bus_addr == ADDR_W'(CFG_BASE + i * CH_STRIDE)) begin
                bus_rdata = cfg_rd[i];
            end
            if (bus_addr == ADDR_W'(INIT_BASE + i * CH_STRIDE)) begin
                bus_rdata = DATA_W'(init_rd[i]);
            end
        end
        if (bus_addr == ADDR_W'(LIVE_OFF)) begin
            bus_rdata = DATA_W'(count[LIVE_CH]);
        end
        if (bus_addr == ADDR_W'(STAT_OFF)) begin
            bus_rdata = DATA_W'(stat);
        end
    end

    // R10: the line follows enabled status bits
    a_r10_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (stat != '0));
endmodule

// File: tb/test_twin_countdown_timer.sv
module test_twin_countdown_timer;
    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 20000;
    localparam int  A_CFG0 = 'h00, A_CFG1 = 'h04, A_INIT0 = 'h08, A_INIT1 = 'h0C;
    localparam int  A_LIVE = 'h14, A_STAT = 'h18;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = 5'(A_LIVE);
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_checks = 0;
    int n_err = 0;
    bit mon_on = 1'b0;

    // behavioural reference state
    int m_run[2], m_ie[2], m_mode[2], m_pre[2], m_init[2], m_cnt[2], m_pend[2], m_div[2];
    int m_stat;
    int old_run, set_bits;
    bit tk, ld;

    always #(CLK_PERIOD / 2) clk = ~clk;

    twin_countdown_timer i_twin_countdown_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int model_read(input int a);
        case (a)
            A_CFG0, A_CFG1: begin
                int c;
                c = (a == A_CFG1) ? 1 : 0;
                return (m_run[c] << 30) | (m_ie[c] << 29) | (m_mode[c] << 27) | m_pre[c];
            end
            A_INIT0: return m_init[0];
            A_INIT1: return m_init[1];
            A_LIVE:  return m_cnt[1];
            A_STAT:  return m_stat;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < 2; c++) begin
                m_run[c] = 0; m_ie[c] = 0; m_mode[c] = 0; m_pre[c] = 1;
                m_init[c] = 0; m_cnt[c] = 0; m_pend[c] = 1; m_div[c] = 0;
            end
            m_stat = 0;
        end else begin
            set_bits = 0;
            for (int c = 0; c < 2; c++) begin
                old_run = m_run[c];
                ld = (m_run[c] != 0) && (m_pend[c] != 0);
                tk = (m_run[c] != 0) && (m_pend[c] == 0) && (m_div[c] >= m_pre[c]);
                if (ld) begin
                    m_cnt[c] = m_init[c]; m_pend[c] = 0; m_div[c] = 0;
                end else if (m_run[c] != 0) begin
                    if (tk) begin
                        m_div[c] = 0;
                        if (m_cnt[c] <= 1) begin
                            set_bits |= (1 << c);
                            if (m_mode[c] % 2 == 1) m_cnt[c] = m_init[c];
                            else begin m_cnt[c] = 0; m_run[c] = 0; m_pend[c] = 1; end
                        end else m_cnt[c] = m_cnt[c] - 1;
                    end else m_div[c] = m_div[c] + 1;
                end
                if (bus_wr && int'(bus_addr) == A_INIT0 + 4 * c) begin
                    m_init[c] = int'(bus_wdata & 32'h00FF_FFFF);
                    if (old_run == 0) m_pend[c] = 1;
                end
                if (bus_wr && int'(bus_addr) == A_CFG0 + 4 * c) begin
                    m_run[c]  = int'(bus_wdata[30]);
                    m_ie[c]   = int'(bus_wdata[29]);
                    m_mode[c] = int'(bus_wdata[28:27]);
                    m_pre[c]  = int'(bus_wdata[7:0]);
                end
            end
            if (bus_wr && int'(bus_addr) == A_STAT) m_stat = m_stat & ~int'(bus_wdata[1:0]);
            m_stat = m_stat | set_bits;
        end
    end

    // cycle-by-cycle comparison against the reference
    always @(negedge clk) begin
        if (mon_on) begin
            chk({31'b0, irq},
                {31'b0, ((m_stat & 1) != 0 && m_ie[0] != 0) || ((m_stat & 2) != 0 && m_ie[1] != 0)},
                "R10 model irq");
            chk(bus_rdata, 32'(model_read(int'(bus_addr))), "R11 model read");
        end
    end

    task automatic wr(input int a, input logic [31:0] d);
        bus_addr = 5'(a); bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk); #1;
        bus_wr = 1'b0; bus_addr = 5'(A_LIVE);
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic rd(input int a, input logic [31:0] exp, input string tag);
        bus_addr = 5'(a); #1;
        chk(bus_rdata, exp, tag);
        bus_addr = 5'(A_LIVE);
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        mon_on = 1'b1;
        // R1 reset values
        rd(A_CFG0, 32'h1, "R1 cfg0"); rd(A_CFG1, 32'h1, "R1 cfg1");
        rd(A_INIT0, 0, "R1 init0"); rd(A_INIT1, 0, "R1 init1");
        rd(A_LIVE, 0, "R1 live"); rd(A_STAT, 0, "R1 status");
        chk({31'b0, irq}, 0, "R1 irq");
        // R2 field layout and unmapped offsets
        wr(A_INIT0, 32'hABCD_EF12); rd(A_INIT0, 32'h00CD_EF12, "R2 init width");
        wr(A_CFG0, 32'hB800_0105);  rd(A_CFG0, 32'h3800_0005, "R2 cfg fields");
        rd('h10, 0, "R2 unmapped 0x10"); rd('h1C, 0, "R2 unmapped 0x1C");
        // R3 / R4 / R11: channel 1 periodic, prescale 1
        wr(A_INIT1, 20);
        wr(A_CFG1, 32'h4800_0001);
        step(1); rd(A_LIVE, 20, "R3 load on first enabled edge");
        step(1); rd(A_LIVE, 20, "R4 no tick before P+1 clocks");
        step(1); rd(A_LIVE, 19, "R4 first decrement");
        step(2); rd(A_LIVE, 18, "R11 live count");
        // R5 stop and resume
        wr(A_CFG1, 32'h0800_0001); rd(A_LIVE, 18, "R5 stop");
        step(4); rd(A_LIVE, 18, "R5 held while stopped");
        wr(A_CFG1, 32'h4800_0001); rd(A_LIVE, 18, "R5 restart edge");
        step(1); rd(A_LIVE, 17, "R5 resumes without reload");
        wr(A_CFG1, 32'h0800_0001); rd(A_LIVE, 17, "R5 stopped again");
        // R8 / R7: new initial count while stopped, periodic reload
        wr(A_INIT1, 5);
        wr(A_CFG1, 32'h4800_0000);
        step(1); rd(A_LIVE, 5, "R8 pending reload taken");
        step(4); rd(A_LIVE, 1, "R7 count before expiry"); rd(A_STAT, 0, "R7 no flag yet");
        step(1); rd(A_LIVE, 5, "R7 periodic reload"); rd(A_STAT, 2, "R7 flag set");
        wr(A_INIT1, 2); rd(A_LIVE, 4, "R8 running write leaves count");
        step(3); rd(A_LIVE, 1, "R8 count down");
        step(1); rd(A_LIVE, 2, "R8 new value used at reload");
        wr(A_CFG1, 32'h0000_0000); rd(A_LIVE, 1, "R5 final stop");
        // R6 one-shot on channel 0, prescale 0
        wr(A_INIT0, 3);
        wr(A_CFG0, 32'h6000_0000);
        step(3); rd(A_STAT, 2, "R6 not expired yet"); chk({31'b0, irq}, 0, "R10 ie1 off");
        step(1); rd(A_STAT, 3, "R6 expiry flag");
        rd(A_CFG0, 32'h2000_0000, "R6 run self-cleared");
        chk({31'b0, irq}, 1, "R10 irq from ch0");
        // R9 / R10 clearing
        wr(A_CFG1, 32'h2000_0000);
        wr(A_STAT, 32'h1); rd(A_STAT, 2, "R9 clear bit0"); chk({31'b0, irq}, 1, "R10 irq from ch1");
        wr(A_STAT, 32'h0); rd(A_STAT, 2, "R9 zero write no effect");
        wr(A_CFG1, 32'h0); chk({31'b0, irq}, 0, "R10 masked by ie");
        wr(A_STAT, 32'h1F); rd(A_STAT, 0, "R9 clear all");
        // R9 race: clear lands on the expiry edge
        wr(A_INIT0, 2);
        wr(A_CFG0, 32'h6000_0000);
        step(2);
        wr(A_STAT, 32'h1); rd(A_STAT, 1, "R9 set wins over clear");
        chk({31'b0, irq}, 1, "R10 irq after race");
        rd(A_CFG0, 32'h2000_0000, "R6 halted after race");
        wr(A_STAT, 32'h1); rd(A_STAT, 0, "R9 later clear");
        step(2);
        mon_on = 1'b0;
        summary();
        $finish;
    end
endmodule